// File: doc/BRIEF.md
# MIDI Serial Byte Receiver

This block recovers 8-bit bytes from an asynchronous serial line running at the fixed MIDI rate of 31,250 bit/s, where one bit lasts 32 µs. The block runs from a 4 MHz system clock. The raw line first passes through a two-flop synchronizer. A free-running divider then produces a tick every 2 µs, which gives 16 ticks per bit.

While idle, the receiver samples the line on each tick. A frame starts when the line was high on one tick and is low on the next. From that tick the receiver counts ticks and decides each bit at its centre. Each decision is a majority vote of three consecutive tick samples. At the centre of the start bit the line is checked a second time, and a high value there discards the edge as a glitch. Data bits arrive least significant bit first. At the centre of the stop bit the byte is presented together with a framing-error flag, and the receiver returns to idle. Frames may follow one another directly or with any gap between them.

Top module: `midi_byte_rx`

## Requirements
- R1: While reset is asserted, and on release, `data_o` is 0x00, `valid_o` is 0 and `ferr_o` is 0. A reset in the middle of a frame discards that frame, and the next frame is received correctly.
- R2: The serial input reaches the receive logic only after two flip-flop stages, so the internal line sample equals `rx_i` from two clocks earlier.
- R3: A frame is one low start bit, 8 data bits sent LSB first, and one stop bit. Each bit lasts 16 ticks of 8 system clocks, which is 128 clocks. The received byte equals the byte that was sent.
- R4: A frame starts only while the receiver is idle, and only when the line sample on one tick is 1 and the sample on the next tick is 0. A high line of any length between frames produces no output.
- R5: If the vote at the centre of the start bit gives 1, the receiver returns to idle and produces no byte.
- R6: Each bit value is the majority of the samples at ticks 7, 8 and 9 within that bit, counted from the start tick. A single disturbed sample among the three does not change the received byte.
- R7: When the stop-bit vote is 0, `ferr_o` is 1 alongside the byte. When the vote is 1, `ferr_o` is 0. The byte is delivered in both cases.
- R8: `valid_o` is high for exactly one system clock per received byte.
- R9: `data_o` and `ferr_o` change only in the cycle where `valid_o` is high, and they hold their values until the next byte arrives.
- R10: Once the stop bit has been sampled, the receiver is idle again and accepts a start bit that follows the stop bit directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 4 MHz system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Raw serial line, high when idle |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-cycle strobe for a new byte |
| ferr_o | output | 1 | Framing error of the last byte |

## Verification
The main sweep sends 64 byte values spread over the full 0 to 255 range, plus all-zeros, all-ones and the eight walking-one patterns. The gaps between frames range from zero up to several ticks. This sweep distinguishes a wrong bit order, a wrong centre offset and a lost back-to-back start. Frames carrying a one-tick pulse at a bit centre separate three-sample voting from single sampling. A short low pulse on an idle line checks glitch rejection at the start bit, and a frame with a low stop bit checks the framing flag. A reset in the middle of a frame, followed by a clean frame, checks recovery.

// File: rtl/midi_rx_pkg.sv
package midi_rx_pkg;
  typedef enum logic {ST_IDLE, ST_RECV} rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/midi_rx_sync.sv
module midi_rx_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= {STAGES{RST_VAL}};
        else         q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= {STAGES{RST_VAL}};
        else         q <= {q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/midi_rx_tick.sv
module midi_rx_tick #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;

  assign tick_o = (cnt == LAST);
endmodule

// File: rtl/midi_rx_vote.sv
module midi_rx_vote
  import midi_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  output logic last_o,
  output logic maj_o
);
  // two previous tick samples; the third is the live line
  logic [1:0] win;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     win <= 2'b11;
    else if (tick_i) win <= {win[0], line_i};

  assign last_o = win[0];
  assign maj_o  = maj3(win[1], win[0], line_i);
endmodule

// File: rtl/midi_rx_fsm.sv
module midi_rx_fsm
  import midi_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              last_i,
  input  logic              maj_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              ferr_o
);
  localparam int unsigned PH_W  = $clog2(OVS);
  localparam int unsigned BIT_W = $clog2(DATA_W + 2);
  localparam int unsigned CNT_W = PH_W + BIT_W;
  localparam logic [PH_W-1:0]  CENTER   = PH_W'(OVS / 2);
  localparam logic [BIT_W-1:0] STOP_IDX = BIT_W'(DATA_W + 1);

  rx_state_e          st;
  logic [CNT_W-1:0]   cnt;
  logic [DATA_W-1:0]  sreg;
  logic [PH_W-1:0]    phase;
  logic [BIT_W-1:0]   bit_idx;
  logic               decide;

  assign phase   = cnt[PH_W-1:0];
  assign bit_idx = cnt[CNT_W-1:PH_W];
  // cnt holds centre+0 on the tick that samples centre+1: window is centre-1..centre+1
  assign decide  = tick_i && (st == ST_RECV) && (phase == CENTER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sreg    <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick_i) begin
        if (st == ST_IDLE) begin
          if (last_i && !line_i) begin
            st  <= ST_RECV;
            cnt <= '0;
          end
        end else begin
          cnt <= cnt + 1'b1;
          if (decide) begin
            if (bit_idx == '0) begin
              if (maj_i) st <= ST_IDLE;  // glitch, not a start bit
            end else if (bit_idx == STOP_IDX) begin
              data_o  <= sreg;
              ferr_o  <= ~maj_i;
              valid_o <= 1'b1;
              st      <= ST_IDLE;
            end else begin
              sreg <= {maj_i, sreg[DATA_W-1:1]};
            end
          end
        end
      end
    end
  end

  assign busy_o = (st == ST_RECV);
endmodule

// File: rtl/midi_byte_rx.sv
module midi_byte_rx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16,
  parameter int unsigned DIV    = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              ferr_o
);
  logic line_s, tick, last, maj, busy;

  midi_rx_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(line_s)
  );

  midi_rx_tick #(.DIV(DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  midi_rx_vote u_vote (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .line_i(line_s),
    .last_o(last), .maj_o(maj)
  );

  midi_rx_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .line_i(line_s),
    .last_i(last), .maj_i(maj), .busy_o(busy),
    .data_o(data_o), .valid_o(valid_o), .ferr_o(ferr_o)
  );
endmodule

// File: rtl/midi_byte_rx_chk.sv
module midi_byte_rx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_i,
  input logic              line_s,
  input logic              busy,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              ferr_o
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;

  p_sync_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2) |-> (line_s == $past(rx_i, 2)));

  p_valid_in_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(busy));

  p_start_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 2'd0 && $rose(busy)) |-> !$past(line_s));

  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_data_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 2'd0 && !valid_o) |-> $stable(data_o));

  p_ferr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 2'd0 && !valid_o) |-> $stable(ferr_o));
endmodule

bind midi_byte_rx midi_byte_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i), .line_s(line_s), .busy(busy),
  .data_o(data_o), .valid_o(valid_o), .ferr_o(ferr_o)
);

// File: tb/midi_byte_rx_bench.sv
module midi_byte_rx_bench;
  localparam int BT = 128;  // clocks per bit: 16 ticks x 8 clocks

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b1;
  logic [7:0] data_o;
  logic       valid_o, ferr_o;

  always #5 clk_i = ~clk_i;

  midi_byte_rx u_midi_byte_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i),
    .data_o(data_o), .valid_o(valid_o), .ferr_o(ferr_o)
  );

  int checks = 0, errors = 0, mchecks = 0, merrors = 0;
  int tx_n = 0, rx_n = 0;
  logic [7:0] exp_d [0:255];
  logic       exp_f [0:255];
  logic       prev_v = 1'b0;
  bit         done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: R3 data, R7 flag, R8 pulse width
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (valid_o && prev_v) begin
        mchecks++; merrors++;
        $display("FAIL R8 actual=valid_high_2_cycles expected=1_cycle");
      end
      if (valid_o) begin
        mchecks += 2;
        if (rx_n >= tx_n) begin
          merrors++;
          $display("FAIL R4 actual=unexpected_byte_%0h expected=none", data_o);
        end else begin
          if (data_o !== exp_d[rx_n]) begin
            merrors++;
            $display("FAIL R3 actual=%0h expected=%0h", data_o, exp_d[rx_n]);
          end
          if (ferr_o !== exp_f[rx_n]) begin
            merrors++;
            $display("FAIL R7 actual=%0b expected=%0b", ferr_o, exp_f[rx_n]);
          end
        end
        rx_n++;
      end
    end
    prev_v <= valid_o && rst_ni;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // glitch_bit >= 0: 8-clock inverted pulse at centre of data bit glitch_bit
  task automatic send(input logic [7:0] b, input logic stop, input int gap, input int glitch_bit);
    exp_d[tx_n] = b;
    exp_f[tx_n] = ~stop;
    tx_n++;
    rx_i = 1'b0; idle(BT);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i];
      if (i == glitch_bit) begin
        idle(BT / 2); rx_i = ~b[i]; idle(8); rx_i = b[i]; idle(BT / 2 - 8);
      end else idle(BT);
    end
    rx_i = stop; idle(BT);
    rx_i = 1'b1; idle(gap);
  endtask

  initial begin
    int base;
    logic [7:0] v;
    idle(5);
    chk(data_o == 8'h00 && !valid_o && !ferr_o, "R1", {data_o, valid_o, ferr_o}, 0);
    rst_ni = 1'b1;
    idle(3);
    chk(data_o == 8'h00 && !valid_o && !ferr_o, "R1", {data_o, valid_o, ferr_o}, 0);

    // long idle: no byte (R4)
    idle(3000);
    chk(rx_n == 0, "R4", rx_n, 0);

    // sweep with varying gaps including zero (R3, R10)
    send(8'h00, 1'b1, 0, -1);
    send(8'hFF, 1'b1, 0, -1);
    for (int i = 0; i < 8; i++) send(8'(1 << i), 1'b1, (i % 3) * 8, -1);
    for (int i = 0; i < 64; i++) send(8'((i * 37 + 5) & 255), 1'b1, (i % 5) * 20, -1);
    idle(BT);
    chk(rx_n == tx_n, "R10", rx_n, tx_n);

    // hold between bytes (R9)
    v = exp_d[tx_n - 1];
    idle(700);
    chk(data_o == v && !ferr_o, "R9", {data_o, ferr_o}, {v, 1'b0});

    // short start glitch, 3 ticks low (R5)
    base = rx_n;
    rx_i = 1'b0; idle(24); rx_i = 1'b1;
    idle(3 * BT);
    chk(rx_n == base, "R5", rx_n, base);
    chk(data_o == v, "R5", data_o, v);

    // single disturbed sample at each data bit centre (R6)
    for (int i = 0; i < 8; i++) send(8'(8'hA5 ^ (8'h11 << (i % 4))), 1'b1, 40, i);
    idle(BT);
    chk(rx_n == tx_n, "R6", rx_n, tx_n);

    // framing error then hold then clear (R7, R9)
    send(8'h3C, 1'b0, BT, -1);
    idle(500);
    chk(ferr_o && data_o == 8'h3C, "R7", {data_o, ferr_o}, {8'h3C, 1'b1});
    send(8'hC3, 1'b1, BT, -1);
    idle(50);
    chk(!ferr_o && data_o == 8'hC3, "R7", {data_o, ferr_o}, {8'hC3, 1'b0});

    // reset mid-frame (R1)
    rx_i = 1'b0; idle(BT);
    rx_i = 1'b1; idle(3 * BT);
    rst_ni = 1'b0;
    idle(2);
    chk(data_o == 8'h00 && !valid_o && !ferr_o, "R1", {data_o, valid_o, ferr_o}, 0);
    idle(6 * BT);
    rst_ni = 1'b1;
    idle(50);
    chk(rx_n == tx_n && data_o == 8'h00, "R1", rx_n, tx_n);
    send(8'h5A, 1'b1, BT, -1);
    idle(20);
    chk(rx_n == tx_n && data_o == 8'h5A, "R1", data_o, 8'h5A);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks + mchecks, errors + merrors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks + mchecks + 1, errors + merrors + 1);
      $finish;
    end
  end
endmodule